// File: doc/BRIEF.md
# Dual-Sided Mailbox Message Unit

Two processors, side A and side B, share this block. Each side reaches it through its own simple 32-bit register port and has four transmit registers, four receive registers, a status register and a control register. A word written into transmit register n on one side lands in receive register n on the other side. Per-slot flags handle the flow of each word: the receiver sees that a slot is full, and the sender sees when the slot is empty again.

Four doorbells in each direction let a side signal its peer without sending data. A doorbell stays pending until the receiving side clears it by writing a 1 to its pending bit. Each side has one interrupt line, formed from its status flags masked by the enables in its own control register. Each side also has a synchronous side-reset input, and the peer can see through its status register that this reset is held.

Top module: `mu_dual`

## Requirements
- R1: After rst_ni, every control register reads 0, each side's status reads 0x00F00000 (all four transmit-empty bits set, nothing full or pending), and both interrupt lines are low.
- R2: Register offsets are as follows: transmit n at 0x00+4n, receive n at 0x10+4n, status at 0x20, control at 0x24. A write to transmit n on one side clears that side's transmit-empty n (status bit 20+(3-n)) and sets receive-full n on the peer (status bit 24+(3-n)). Reading the peer's receive n returns the word. Both directions and all slots are independent.
- R3: Reading receive n clears the local receive-full n and sets transmit-empty n again on the sending side.
- R4: Writing transmit n while its word is still unread replaces that word with no error flag. The reader gets the newest word, and one read empties the slot.
- R5: Writing 1 to control bit 16+(3-n) requests doorbell n. The peer's pending bit 28+(3-n) then sets, and the request bit clears itself once the pending bit is seen. Writing 0 to a request bit does not cancel it.
- R6: A pending doorbell clears only when its own status bit is written as 1. Status writes have no effect on the full and empty flags or on any pending bit written as 0.
- R7: The interrupt is high when any of these holds: pending n with enable bit 28+(3-n), receive-full n with enable 24+(3-n), or transmit-empty n with enable 23-n... stated precisely as 20+(3-n).
- R8: While a side's reset input is high, its control register and pending flags are held at 0, its register accesses are ignored, its interrupt is low, and the peer's status bit 9 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, whole block |
| a_srst_i | input | 1 | Side A synchronous reset |
| a_sel_i | input | 1 | Side A access strobe |
| a_we_i | input | 1 | Side A write (1) or read (0) |
| a_addr_i | input | 6 | Side A byte address |
| a_wdata_i | input | 32 | Side A write data |
| a_rdata_o | output | 32 | Side A read data, valid during the read cycle |
| a_irq_o | output | 1 | Side A interrupt |
| b_srst_i | input | 1 | Side B synchronous reset |
| b_sel_i | input | 1 | Side B access strobe |
| b_we_i | input | 1 | Side B write (1) or read (0) |
| b_addr_i | input | 6 | Side B byte address |
| b_wdata_i | input | 32 | Side B write data |
| b_rdata_o | output | 32 | Side B read data, valid during the read cycle |
| b_irq_o | output | 1 | Side B interrupt |

## Verification
Words go from A to B in a middle slot and from B to A in the two end slots at once. The status values that result show that the reversed bit order is correct and that the slots do not interfere. A double write followed by one read tells overwrite apart from queuing. Doorbells are rung on channel 3 and channel 2, then cleared with a zero write, a write to unrelated bits, and the true one-bit write; this separates set-only behaviour from write-one-to-clear. The interrupt is driven by each of the three flag kinds in turn. A side reset is applied with accesses made while it is held.

// File: rtl/mu_pkg.sv
package mu_pkg;
  localparam int NUM_CH   = 4;
  localparam int ADDR_W   = 6;
  localparam int REG_W    = 32;
  localparam int OFS_TX   = 'h00;
  localparam int OFS_RX   = 'h10;
  localparam int OFS_STAT = 'h20;
  localparam int OFS_CTRL = 'h24;
  localparam int POS_DB   = 28;
  localparam int POS_RF   = 24;
  localparam int POS_TE   = 20;
  localparam int POS_REQ  = 16;
  localparam int POS_PRST = 9;

  // channel n sits at base+(NUM_CH-1-n): reversed order
  function automatic int ch_bit(int base, int n);
    return base + (NUM_CH - 1 - n);
  endfunction
endpackage

// File: rtl/mu_slot.sv
module mu_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
    end else if (wr_i) begin
      data_o <= wdata_i;
      full_o <= 1'b1;
    end else if (rd_i) begin
      full_o <= 1'b0;
    end
  end

  a_r2_write_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> full_o && data_o == $past(wdata_i));
  a_r3_read_drains: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !wr_i |=> !full_o);
  a_r4_no_write_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(data_o));
endmodule

// File: rtl/mu_side.sv
module mu_side
  import mu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           srst_i,
  input  logic                           peer_srst_i,
  input  logic                           sel_i,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [REG_W-1:0]               wdata_i,
  output logic [REG_W-1:0]               rdata_o,
  output logic                           irq_o,
  output logic [NUM_CH-1:0]              tx_wr_o,
  output logic [DATA_W-1:0]              tx_wdata_o,
  input  logic [NUM_CH-1:0]              tx_full_i,
  output logic [NUM_CH-1:0]              rx_rd_o,
  input  logic [NUM_CH-1:0]              rx_full_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  rx_data_i,
  output logic [NUM_CH-1:0]              db_req_o,
  input  logic [NUM_CH-1:0]              peer_req_i,
  output logic [NUM_CH-1:0]              db_pend_o,
  input  logic [NUM_CH-1:0]              peer_pend_i
);
  logic acc, wr, rd, wr_stat, wr_ctrl, rd_stat, rd_ctrl;
  logic [NUM_CH-1:0] gie, rie, tie, req, pend;
  logic [NUM_CH-1:0] w_gie, w_rie, w_tie, w_req, w_clr, tx_empty;
  logic [REG_W-1:0]  stat_w, ctrl_w;

  assign acc     = sel_i & ~srst_i;
  assign wr      = acc & we_i;
  assign rd      = acc & ~we_i;
  assign wr_stat = wr && addr_i == ADDR_W'(OFS_STAT);
  assign wr_ctrl = wr && addr_i == ADDR_W'(OFS_CTRL);
  assign rd_stat = rd && addr_i == ADDR_W'(OFS_STAT);
  assign rd_ctrl = rd && addr_i == ADDR_W'(OFS_CTRL);
  assign tx_wdata_o = wdata_i[DATA_W-1:0];
  assign tx_empty   = ~tx_full_i;
  assign db_req_o   = req;
  assign db_pend_o  = pend;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign tx_wr_o[n] = wr && addr_i == ADDR_W'(OFS_TX + 4*n);
    assign rx_rd_o[n] = rd && addr_i == ADDR_W'(OFS_RX + 4*n);
    assign w_gie[n]   = wdata_i[ch_bit(POS_DB, n)];
    assign w_rie[n]   = wdata_i[ch_bit(POS_RF, n)];
    assign w_tie[n]   = wdata_i[ch_bit(POS_TE, n)];
    assign w_req[n]   = wdata_i[ch_bit(POS_REQ, n)];
    assign w_clr[n]   = wdata_i[ch_bit(POS_DB, n)];

    a_r5_req_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req[n] && peer_pend_i[n] && !(wr_ctrl && w_req[n]) |=> !req[n]);
    a_r6_pend_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend[n] && !srst_i && !(wr_stat && w_clr[n]) |=> pend[n]);
    a_r6_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_stat && w_clr[n] && !peer_req_i[n] |=> !pend[n]);
  end

  always_comb begin
    stat_w = '0;
    ctrl_w = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      stat_w[ch_bit(POS_DB, n)]  = pend[n];
      stat_w[ch_bit(POS_RF, n)]  = rx_full_i[n];
      stat_w[ch_bit(POS_TE, n)]  = tx_empty[n];
      ctrl_w[ch_bit(POS_DB, n)]  = gie[n];
      ctrl_w[ch_bit(POS_RF, n)]  = rie[n];
      ctrl_w[ch_bit(POS_TE, n)]  = tie[n];
      ctrl_w[ch_bit(POS_REQ, n)] = req[n];
    end
    stat_w[POS_PRST] = peer_srst_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_stat) rdata_o = stat_w;
    if (rd_ctrl) rdata_o = ctrl_w;
    for (int n = 0; n < NUM_CH; n++)
      if (rx_rd_o[n]) rdata_o = REG_W'(rx_data_i[n]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie <= '0; rie <= '0; tie <= '0; req <= '0; pend <= '0;
    end else if (srst_i) begin
      gie <= '0; rie <= '0; tie <= '0; req <= '0; pend <= '0;
    end else begin
      if (wr_ctrl) begin
        gie <= w_gie;
        rie <= w_rie;
        tie <= w_tie;
      end
      req  <= (req & ~peer_pend_i) | (wr_ctrl ? w_req : '0);
      pend <= (pend & ~(wr_stat ? w_clr : '0)) | peer_req_i;
    end
  end

  assign irq_o = |(pend & gie) | |(rx_full_i & rie) | |(tx_empty & tie);

  a_r8_srst_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> !irq_o && pend == '0);
endmodule

// File: rtl/mu_dual.sv
module mu_dual
  import mu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_srst_i,
  input  logic              a_sel_i,
  input  logic              a_we_i,
  input  logic [5:0]        a_addr_i,
  input  logic [31:0]       a_wdata_i,
  output logic [31:0]       a_rdata_o,
  output logic              a_irq_o,
  input  logic              b_srst_i,
  input  logic              b_sel_i,
  input  logic              b_we_i,
  input  logic [5:0]        b_addr_i,
  input  logic [31:0]       b_wdata_i,
  output logic [31:0]       b_rdata_o,
  output logic              b_irq_o
);
  logic [NUM_CH-1:0]             ab_wr, ab_rd, ab_full, ba_wr, ba_rd, ba_full;
  logic [NUM_CH-1:0][DATA_W-1:0] ab_data, ba_data;
  logic [DATA_W-1:0]             a_txd, b_txd;
  logic [NUM_CH-1:0]             a_req, b_req, a_pend, b_pend;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_slot
    mu_slot #(.DATA_W(DATA_W)) u_ab (
      .clk_i, .rst_ni, .wr_i(ab_wr[n]), .wdata_i(a_txd), .rd_i(ab_rd[n]),
      .data_o(ab_data[n]), .full_o(ab_full[n]));
    mu_slot #(.DATA_W(DATA_W)) u_ba (
      .clk_i, .rst_ni, .wr_i(ba_wr[n]), .wdata_i(b_txd), .rd_i(ba_rd[n]),
      .data_o(ba_data[n]), .full_o(ba_full[n]));
  end

  mu_side #(.DATA_W(DATA_W)) u_side_a (
    .clk_i, .rst_ni, .srst_i(a_srst_i), .peer_srst_i(b_srst_i),
    .sel_i(a_sel_i), .we_i(a_we_i), .addr_i(a_addr_i), .wdata_i(a_wdata_i),
    .rdata_o(a_rdata_o), .irq_o(a_irq_o),
    .tx_wr_o(ab_wr), .tx_wdata_o(a_txd), .tx_full_i(ab_full),
    .rx_rd_o(ba_rd), .rx_full_i(ba_full), .rx_data_i(ba_data),
    .db_req_o(a_req), .peer_req_i(b_req), .db_pend_o(a_pend), .peer_pend_i(b_pend));

  mu_side #(.DATA_W(DATA_W)) u_side_b (
    .clk_i, .rst_ni, .srst_i(b_srst_i), .peer_srst_i(a_srst_i),
    .sel_i(b_sel_i), .we_i(b_we_i), .addr_i(b_addr_i), .wdata_i(b_wdata_i),
    .rdata_o(b_rdata_o), .irq_o(b_irq_o),
    .tx_wr_o(ba_wr), .tx_wdata_o(b_txd), .tx_full_i(ba_full),
    .rx_rd_o(ab_rd), .rx_full_i(ab_full), .rx_data_i(ab_data),
    .db_req_o(b_req), .peer_req_i(a_req), .db_pend_o(b_pend), .peer_pend_i(a_pend));
endmodule

// File: tb/tb_mu_dual.sv
`timescale 1ns/1ps
module tb_mu_dual;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic a_srst_i = 0, a_sel_i = 0, a_we_i = 0, b_srst_i = 0, b_sel_i = 0, b_we_i = 0;
  logic [5:0]  a_addr_i = '0, b_addr_i = '0;
  logic [31:0] a_wdata_i = '0, b_wdata_i = '0, a_rdata_o, b_rdata_o;
  logic a_irq_o, b_irq_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  mu_dual dut (.*);

  localparam logic [5:0] STAT = 6'h20, CTRL = 6'h24;
  localparam logic [31:0] IDLE = 32'h00F0_0000;

  function automatic logic [31:0] bt(int base, int n);
    return 32'h1 << (base + 3 - n);
  endfunction
  function automatic logic [5:0] txa(int n); return 6'(4*n); endfunction
  function automatic logic [5:0] rxa(int n); return 6'(16 + 4*n); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(bit s, logic [5:0] a, logic [31:0] d);
    @(negedge clk_i);
    if (s) begin b_sel_i = 1; b_we_i = 1; b_addr_i = a; b_wdata_i = d; end
    else   begin a_sel_i = 1; a_we_i = 1; a_addr_i = a; a_wdata_i = d; end
    @(negedge clk_i);
    a_sel_i = 0; a_we_i = 0; b_sel_i = 0; b_we_i = 0;
  endtask

  task automatic rd(bit s, logic [5:0] a, output logic [31:0] d);
    @(negedge clk_i);
    if (s) begin b_sel_i = 1; b_we_i = 0; b_addr_i = a; end
    else   begin a_sel_i = 1; a_we_i = 0; a_addr_i = a; end
    #1 d = s ? b_rdata_o : a_rdata_o;
    @(negedge clk_i);
    a_sel_i = 0; b_sel_i = 0;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, STAT, d); chk("R1 a stat", d, IDLE);
    rd(1, STAT, d); chk("R1 b stat", d, IDLE);
    rd(0, CTRL, d); chk("R1 a ctrl", d, 0);
    rd(1, CTRL, d); chk("R1 b ctrl", d, 0);
    chk("R1 irqs", {a_irq_o, b_irq_o}, 0);
  endtask

  task automatic t_transfer();
    logic [31:0] d;
    wr(0, txa(2), 32'hCAFE_0002);
    rd(0, STAT, d); chk("R2 a te2 clr", d, IDLE & ~bt(20, 2));
    rd(1, STAT, d); chk("R2 b rf2 set", d, IDLE | bt(24, 2));
    rd(1, rxa(2), d); chk("R2 b rx2 data", d, 32'hCAFE_0002);
    rd(1, STAT, d); chk("R3 b rf2 clr", d, IDLE);
    rd(0, STAT, d); chk("R3 a te2 set", d, IDLE);
    wr(1, txa(0), 32'h1111_0000);
    wr(1, txa(3), 32'h3333_0003);
    rd(0, STAT, d); chk("R2 a rf0 rf3", d, IDLE | bt(24, 0) | bt(24, 3));
    rd(1, STAT, d); chk("R2 b te0 te3 clr", d, IDLE & ~bt(20, 0) & ~bt(20, 3));
    rd(0, rxa(3), d); chk("R2 a rx3 data", d, 32'h3333_0003);
    rd(0, rxa(0), d); chk("R2 a rx0 data", d, 32'h1111_0000);
    rd(1, STAT, d); chk("R3 b te restored", d, IDLE);
  endtask

  task automatic t_overwrite();
    logic [31:0] d;
    wr(0, txa(1), 32'hAAAA_0001);
    wr(0, txa(1), 32'hBBBB_0001);
    rd(1, STAT, d); chk("R4 only rf1", d, IDLE | bt(24, 1));
    rd(1, rxa(1), d); chk("R4 newest word", d, 32'hBBBB_0001);
    rd(1, STAT, d); chk("R4 one read empties", d, IDLE);
    rd(0, STAT, d); chk("R4 a te1 back", d, IDLE);
  endtask

  task automatic t_doorbell();
    logic [31:0] d;
    wr(0, CTRL, bt(16, 3));
    idle(3);
    rd(1, STAT, d); chk("R5 b pend3", d, IDLE | bt(28, 3));
    rd(0, CTRL, d); chk("R5 req self clear", d, 0);
    wr(1, STAT, 32'h0);
    rd(1, STAT, d); chk("R6 zero write keeps", d, IDLE | bt(28, 3));
    wr(1, STAT, 32'h0FF0_0200 | bt(28, 0));
    rd(1, STAT, d); chk("R6 other bits no effect", d, IDLE | bt(28, 3));
    wr(1, STAT, bt(28, 3));
    rd(1, STAT, d); chk("R6 w1c", d, IDLE);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(0, CTRL, bt(24, 0));
    idle(1); chk("R7 no rf irq low", a_irq_o, 0);
    wr(1, txa(0), 32'h5);
    idle(1); chk("R7 rf irq", a_irq_o, 1);
    rd(0, rxa(0), d);
    idle(1); chk("R7 rf irq drop", a_irq_o, 0);
    wr(0, CTRL, bt(20, 1));
    idle(1); chk("R7 te irq", a_irq_o, 1);
    wr(0, CTRL, bt(28, 2));
    idle(1); chk("R7 gie idle low", a_irq_o, 0);
    wr(1, CTRL, bt(16, 2));
    idle(3); chk("R7 db irq", a_irq_o, 1);
    wr(0, STAT, bt(28, 2));
    idle(1); chk("R7 db irq cleared", a_irq_o, 0);
    wr(0, CTRL, 0);
  endtask

  task automatic t_side_reset();
    logic [31:0] d;
    wr(1, CTRL, 32'h00F0_0000);
    idle(1); chk("R7 b te irq", b_irq_o, 1);
    @(negedge clk_i); b_srst_i = 1;
    idle(1); chk("R8 irq low in reset", b_irq_o, 0);
    rd(0, STAT, d); chk("R8 peer reset flag", d, IDLE | 32'h200);
    wr(1, CTRL, 32'h00F0_0000);
    wr(1, txa(0), 32'hDEAD);
    @(negedge clk_i); b_srst_i = 0;
    rd(1, CTRL, d); chk("R8 ctrl cleared, write ignored", d, 0);
    rd(0, STAT, d); chk("R8 tx write ignored", d, IDLE);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_ni = 1;
    idle(1);
    t_reset();
    t_transfer();
    t_overwrite();
    t_doorbell();
    t_irq();
    t_side_reset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule